// File: doc/BRIEF.md
# Dual-Rail Four-Phase Word Link

This block carries a data word from a sender to a receiver over dual-rail wires. Every data bit travels on its own pair of wires. A pair can hold a spacer, a zero, a one, or an illegal value. The receiver finds out that a word has arrived by looking at the pairs themselves: no strobe and no shared clock edge marks the word. Transfers follow a four-phase request/acknowledge protocol. The sender drives the code, waits for the acknowledge to rise, returns every pair to spacer, and waits for the acknowledge to fall before it accepts another word.

On the single-rail side the sender takes words through a valid/ready handshake. The receiver presents each decoded word on a one-cycle valid pulse. It also keeps a sticky error flag, which records any pair seen holding the illegal value. Both halves run on one clock so the whole link can be simulated. The dual-rail wires and the acknowledge leave the top as ports. The environment joins them, and it may add per-bit skew or faults on the way.

Top module: `dr_link`

## Requirements
- R1: While reset is high and in the first cycle after it, every transmit pair and the receive acknowledge are low, in_ready is high, out_valid is low and err_flag is low.
- R2: Bit i of a word travels on pair i, which is rails bits [2i+1:2i] with the upper wire at 2i+1. Logic 1 is coded 10, logic 0 is coded 01, and 00 is the spacer.
- R3: A word is taken on a clock edge where in_valid and in_ready are both high. From the next cycle in_ready stays low until the sender has seen the acknowledge fall. in_ready is only ever high while the transmit pairs are all spacer and the seen acknowledge is low.
- R4: The sender holds the full code of the accepted word on its pairs until it sees the acknowledge high. Only then does it drive every pair to 00.
- R5: The receiver raises its acknowledge only after a cycle in which every pair held 01 or 10. In that same cycle it gives a single-cycle out_valid pulse, with out_data decoded from the pairs. A word with any pair still at spacer is not acknowledged.
- R6: A raised acknowledge falls only after a cycle in which every pair held 00. A partly returned word keeps it high.
- R7: A pair at 11 is never taken as data, so a word that contains one is not acknowledged. Seeing such a pair sets err_flag, which stays set until reset.
- R8: The sender never drives 11 on any pair.
- R9: Words reach out_data in the order they were accepted, with their values unchanged, whatever the per-bit skew between the wires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | WIDTH | Single-rail word to send |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Sender can take a word |
| tx_rails | output | 2*WIDTH | Dual-rail pairs driven by the sender |
| tx_ack | input | 1 | Acknowledge as seen by the sender |
| rx_rails | input | 2*WIDTH | Dual-rail pairs as seen by the receiver |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| out_data | output | WIDTH | Decoded word |
| out_valid | output | 1 | One-cycle pulse marking a new word |
| err_flag | output | 1 | Sticky illegal-pair flag |

## Verification
The hardest case to reach is a receiver that sees an illegal pair or a half-formed word. A correct sender never produces either, and the per-bit skew only shows partial words for a cycle or two. The bench therefore joins the two halves through a behavioural channel that copies each pair and the acknowledge with random lag. This covers ordering and completion under skew. For a second phase the bench takes the receiver's wires over directly. It holds partial words, partial returns to spacer and a word with one 11 pair for several cycles, and checks that the acknowledge and the error flag react only as required.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam logic [1:0] PAIR_SPACER = 2'b00;
  localparam logic [1:0] PAIR_ZERO   = 2'b01;
  localparam logic [1:0] PAIR_ONE    = 2'b10;
  localparam logic [1:0] PAIR_BAD    = 2'b11;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_RTZ  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dr_pair_class.sv
module dr_pair_class
  import dr_pkg::*;
(
  input  logic [1:0] pair,
  output logic       is_data,
  output logic       is_spacer,
  output logic       is_bad,
  output logic       bit_val
);
  always_comb begin
    is_data   = (pair == PAIR_ZERO) || (pair == PAIR_ONE);
    is_spacer = (pair == PAIR_SPACER);
    is_bad    = (pair == PAIR_BAD);
    bit_val   = (pair == PAIR_ONE);
  end
endmodule

// File: rtl/dr_tx.sv
module dr_tx
  import dr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [RW-1:0]    rails_o,
  input  logic             ack_i
);
  tx_state_e          st;
  logic [RW-1:0]      code;

  for (genvar i = 0; i < WIDTH; i++) begin : g_enc
    assign code[2*i+1 -: 2] = in_data[i] ? PAIR_ONE : PAIR_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      rails_o  <= '0;
      in_ready <= 1'b1;
    end else begin
      unique case (st)
        TX_IDLE: if (in_valid && in_ready) begin
          rails_o  <= code;
          in_ready <= 1'b0;
          st       <= TX_DATA;
        end
        TX_DATA: if (ack_i) begin
          rails_o <= '0;
          st      <= TX_RTZ;
        end
        TX_RTZ: if (!ack_i) begin
          in_ready <= 1'b1;
          st       <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R8: no pair ever driven to the illegal value
  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < WIDTH; i++) begin
        a_r8_tx_no_bad: assert (rails_o[2*i+1 -: 2] != PAIR_BAD)
          else $error("R8: sender drove 11 on pair %0d", i);
      end
    end
  end

  // R3: ready drops after a word is taken
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R4: code held until acknowledge seen
  a_r4_hold_code: assert property (@(posedge clk) disable iff (rst)
    (st == TX_DATA && !ack_i) |=> $stable(rails_o));

  // R3: ready only returns once acknowledge was seen low
  a_r3_ready_after_ack_low: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> !$past(ack_i));
endmodule

// File: rtl/dr_rx.sv
module dr_rx
  import dr_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int RW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    rails_i,
  output logic             ack_o,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  output logic             err_o
);
  logic [WIDTH-1:0] pr_data, pr_spacer, pr_bad, pr_bit;
  logic             all_data, all_spacer, any_bad;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cls
    dr_pair_class u_cls (
      .pair      (rails_i[2*i+1 -: 2]),
      .is_data   (pr_data[i]),
      .is_spacer (pr_spacer[i]),
      .is_bad    (pr_bad[i]),
      .bit_val   (pr_bit[i])
    );
  end

  assign all_data   = &pr_data;
  assign all_spacer = &pr_spacer;
  assign any_bad    = |pr_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      err_o     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (any_bad) err_o <= 1'b1;
      if (!ack_o && all_data) begin
        ack_o     <= 1'b1;
        out_valid <= 1'b1;
        out_data  <= pr_bit;
      end else if (ack_o && all_spacer) begin
        ack_o <= 1'b0;
      end
    end
  end

  // R5: acknowledge rises only on a complete word
  a_r5_ack_needs_word: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(all_data));

  // R5: valid pulse coincides with the acknowledge rising
  a_r5_valid_on_rise: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ack_o && !$past(ack_o)));

  // R6: acknowledge falls only after a full return to spacer
  a_r6_fall_needs_spacer: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> $past(all_spacer));

  // R7: illegal pair never acknowledged
  a_r7_bad_not_acked: assert property (@(posedge clk) disable iff (rst)
    (any_bad && !ack_o) |=> !ack_o);

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
endmodule

// File: rtl/dr_link.sv
module dr_link #(
  parameter int WIDTH = 8,
  localparam int RW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [RW-1:0]    tx_rails,
  input  logic             tx_ack,
  input  logic [RW-1:0]    rx_rails,
  output logic             rx_ack,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  output logic             err_flag
);
  dr_tx #(.WIDTH(WIDTH)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .rails_o  (tx_rails),
    .ack_i    (tx_ack)
  );

  dr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rails_i   (rx_rails),
    .ack_o     (rx_ack),
    .out_data  (out_data),
    .out_valid (out_valid),
    .err_o     (err_flag)
  );
endmodule

// File: tb/dr_link_tb.sv
`timescale 1ns/1ps
module dr_link_tb_top;
  localparam int W  = 8;
  localparam int RW = 2 * W;
  localparam int NWORDS = 40;
  localparam int WD_LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [RW-1:0] tx_rails;
  logic          tx_ack_b = 1'b0;
  logic [RW-1:0] rx_rails;
  logic          rx_ack;
  logic [W-1:0]  out_data;
  logic          out_valid;
  logic          err_flag;

  logic          ovr = 1'b0;
  logic [RW-1:0] ovr_rails = '0;
  logic [RW-1:0] chan_rails = '0;

  assign rx_rails = ovr ? ovr_rails : chan_rails;

  always #4 clk = ~clk;

  dr_link #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_rails(tx_rails), .tx_ack(tx_ack_b),
    .rx_rails(rx_rails), .rx_ack(rx_ack), .out_data(out_data),
    .out_valid(out_valid), .err_flag(err_flag)
  );

  int n_checks = 0;
  int n_errs   = 0;
  int delivered = 0;
  int cycles   = 0;
  logic [W-1:0] send_q[$];
  logic [W-1:0] exp_q[$];
  logic [W-1:0] inflight = '0;
  logic          acc_pending = 1'b0;
  logic [RW-1:0] prev_tx = '0;
  logic          prev_rx_ack = 1'b0;

  function automatic logic [RW-1:0] enc(input logic [W-1:0] w);
    logic [RW-1:0] r;
    for (int i = 0; i < W; i++) r[2*i+1 -: 2] = w[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic bit full_word(input logic [RW-1:0] r);
    for (int i = 0; i < W; i++)
      if (!(r[2*i+1 -: 2] == 2'b01 || r[2*i+1 -: 2] == 2'b10)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  // reference model, checks, stimulus and skewed channel
  always @(negedge clk) begin
    if (!rst && !ovr) begin
      if (acc_pending) begin
        check(in_ready == 1'b0, "R3 ready low after accept", in_ready, 0);
        acc_pending = 1'b0;
        in_valid = 1'b0;
      end
      if (in_ready)
        check(tx_rails == '0 && !tx_ack_b, "R3 ready only while idle", tx_rails, 0);
      check(tx_rails == '0 || tx_rails == enc(inflight), "R2 R8 sender code",
            tx_rails, enc(inflight));
      if (prev_tx != '0 && tx_rails == '0)
        check(tx_ack_b, "R4 spacer only after ack", tx_ack_b, 1);
      if (rx_ack && !prev_rx_ack) begin
        check(full_word(chan_rails), "R5 ack needs complete word", chan_rails, 0);
        check(out_valid, "R5 valid with ack rise", out_valid, 1);
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected word", out_data, 0);
        else begin
          check(out_data == exp_q[0], "R9 word order and value", out_data, exp_q[0]);
          void'(exp_q.pop_front());
          delivered++;
        end
      end else begin
        check(!out_valid, "R5 valid only on ack rise", out_valid, 0);
      end
      if (!rx_ack && prev_rx_ack)
        check(chan_rails == '0, "R6 ack falls on full spacer", chan_rails, 0);
      check(!err_flag, "R7 no error on clean link", err_flag, 0);
      prev_tx = tx_rails;
      prev_rx_ack = rx_ack;

      if (!in_valid && send_q.size() > 0 && ($urandom % 3) != 0) begin
        in_valid = 1'b1;
        in_data  = send_q[0];
      end
      if (in_valid && in_ready && !acc_pending) begin
        exp_q.push_back(in_data);
        inflight = in_data;
        void'(send_q.pop_front());
        acc_pending = 1'b1;
      end

      for (int i = 0; i < W; i++)
        if ($urandom % 2) chan_rails[2*i+1 -: 2] = tx_rails[2*i+1 -: 2];
      if ($urandom % 2) tx_ack_b = rx_ack;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        check(1'b0, "watchdog expired", cycles, WD_LIMIT);
        finish_run();
      end
    end
  end

  initial begin
    logic [RW-1:0] full, part, bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_rails == '0, "R1 tx rails after reset", tx_rails, 0);
    check(!rx_ack, "R1 ack after reset", rx_ack, 0);
    check(in_ready, "R1 ready after reset", in_ready, 1);
    check(!out_valid && !err_flag, "R1 valid/err after reset", {out_valid, err_flag}, 0);

    send_q.push_back(8'h00); send_q.push_back(8'hFF);
    send_q.push_back(8'hAA); send_q.push_back(8'h55);
    for (int k = 4; k < NWORDS; k++) send_q.push_back(W'($urandom));
    rst = 1'b0;
    @(negedge clk);
    check(tx_rails == '0 && !rx_ack && in_ready, "R1 first cycle after reset",
          {in_ready, rx_ack}, 2);

    while (send_q.size() != 0 || exp_q.size() != 0 || !in_ready || tx_ack_b || rx_ack)
      @(negedge clk);
    check(delivered == NWORDS, "R9 all words delivered", delivered, NWORDS);

    // direct drive of receiver wires
    rst = 1'b1;
    ovr = 1'b1;
    ovr_rails = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    full = enc(8'h5A);
    part = full; part[15:14] = 2'b00;
    ovr_rails = part;
    repeat (3) @(negedge clk);
    check(!rx_ack && !out_valid, "R5 partial word not acked", rx_ack, 0);
    ovr_rails = full;
    @(negedge clk);
    check(rx_ack && out_valid, "R5 ack and valid on full word", {rx_ack, out_valid}, 3);
    check(out_data == 8'h5A, "R2 decoded value", out_data, 8'h5A);
    @(negedge clk);
    check(!out_valid && rx_ack, "R5 valid is one cycle", {rx_ack, out_valid}, 2);
    part = '0; part[5:4] = full[5:4];
    ovr_rails = part;
    repeat (3) @(negedge clk);
    check(rx_ack, "R6 partial return keeps ack", rx_ack, 1);
    ovr_rails = '0;
    @(negedge clk);
    check(!rx_ack, "R6 ack falls on spacer", rx_ack, 0);
    bad = full; bad[7:6] = 2'b11;
    ovr_rails = bad;
    repeat (3) @(negedge clk);
    check(!rx_ack && !out_valid, "R7 illegal pair not acked", rx_ack, 0);
    check(err_flag, "R7 error flag set", err_flag, 1);
    ovr_rails = '0;
    @(negedge clk);
    ovr_rails = enc(8'h3C);
    @(negedge clk);
    check(rx_ack && out_data == 8'h3C, "R7 later clean word still taken", out_data, 8'h3C);
    check(err_flag, "R7 error flag sticky", err_flag, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!err_flag && !rx_ack, "R7 R1 reset clears error", err_flag, 0);
    finish_run();
  end
endmodule